// File: doc/BRIEF.md
# Weighted High/Low Transmit Queue Arbiter

This block decides which of two transmit queues, a high-priority one and a low-priority one, provides the next packet to a transmitter. Each queue reports only whether it holds at least one packet. A 3-bit weight code sets how many high packets are sent for every low packet while both queues have traffic. The top code instead selects strict priority, where the low queue is served only while the high queue is empty.

Decisions are made only at packet boundaries. A boundary is either an idle cycle, when no packet is granted, or the cycle in which the transmitter pulses its packet-done strobe. The new grant appears on the following clock edge and is held for one whole packet. A running count of high packets sent since the last low packet decides when the low queue gets its turn. That count is cleared whenever a low packet completes, and also whenever the high queue is found empty at a boundary. As a result, an interrupted burst of high traffic restarts its quota from zero.

Top module: `hl_weighted_arb`

## Requirements
- R1: While both queues are non-empty, the arbiter serves Q high packets and then one low packet, over and over. Q is 1 for weight code 0, and 2 times the code for codes 1 to 6 (2, 4, 6, 8, 10, 12). A high grant is grant = 2'b01 and a low grant is grant = 2'b10.
- R2: With weight code 7, a high grant is given at every boundary where the high queue is non-empty. The low queue is granted only at boundaries where the high queue is empty.
- R3: If the high queue is empty at a boundary, the high-packet count returns to zero. When high packets arrive again, a full quota of Q high packets is served before the next low packet.
- R4: Once a grant is given, grant and grant_valid stay unchanged until the cycle after pkt_done. This holds even if the pending flags change during the packet.
- R5: At a boundary where only one queue is non-empty, that queue is granted, whatever the count and the weight code are.
- R6: When a low packet completes, the high-packet count returns to zero, so the next full quota of high packets follows.
- R7: The grant changes on the first clock edge after pkt_done. pkt_done has no effect while nothing is granted. After reset, and whenever both queues are empty at a boundary, grant is 2'b00 and grant_valid is 0.
- R8: The weight code is used only at boundaries. A change during a packet leaves the current grant unchanged and decides the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_pend | input | 1 | High queue holds at least one packet |
| lo_pend | input | 1 | Low queue holds at least one packet |
| weight_code | input | WEIGHT_W | Ratio code; all-ones selects strict priority |
| pkt_done | input | 1 | One-cycle strobe: the granted packet has finished |
| grant | output | 2 | One-hot grant: bit 0 high queue, bit 1 low queue |
| grant_valid | output | 1 | A queue is currently granted |

## Verification
The situation hardest to reach from the ports is the high queue running dry partway through its quota, after which the count must restart from zero. The stimulus serves part of a quota, drops both pending flags at a boundary, then restores both. It then counts the full run of high grants before the next low grant. The ratio sweep also walks every weight code through several complete high/low rounds. A weight change is placed in the middle of a packet to show that only the next boundary is affected.

// File: rtl/hl_arb_pkg.sv
package hl_arb_pkg;
   // bit positions inside the one-hot grant
   localparam int unsigned GNT_HI = 0;
   localparam int unsigned GNT_LO = 1;

   // high packets per low packet for a non-strict weight code
   function automatic int unsigned quota_of(input int unsigned code);
      return (code == 0) ? 1 : 2 * code;
   endfunction
endpackage

// File: rtl/hl_quota_dec.sv
module hl_quota_dec #(
   parameter int unsigned WEIGHT_W = 3,
   parameter int unsigned CNT_W    = 4
) (
   input  logic [WEIGHT_W-1:0] code,
   output logic [CNT_W-1:0]    quota,
   output logic                strict
);
   import hl_arb_pkg::*;

   localparam int unsigned NUM_CODES = 2 ** WEIGHT_W;

   logic [CNT_W-1:0] quota_tbl [NUM_CODES];

   // one table entry per code, computed at elaboration
   for (genvar c = 0; c < NUM_CODES; c++) begin : g_tbl
      if (c == NUM_CODES - 1) begin : g_strict
         assign quota_tbl[c] = '1;
      end else begin : g_ratio
         assign quota_tbl[c] = CNT_W'(quota_of(c));
      end
   end

   assign quota  = quota_tbl[code];
   assign strict = &code;
endmodule

// File: rtl/hl_ratio_cnt.sv
module hl_ratio_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arb_pt,
   input  logic             done_hi,
   input  logic             done_lo,
   input  logic             hi_pend,
   output logic [CNT_W-1:0] cnt_next
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      cnt_next = cnt_q;
      if (arb_pt) begin
         if (done_hi) begin
            cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
         end else if (done_lo) begin
            cnt_next = '0;
         end
         // high queue found empty: the partial quota is abandoned
         if (!hi_pend) begin
            cnt_next = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_next;
      end
   end
endmodule

// File: rtl/hl_grant_pick.sv
module hl_grant_pick #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             hi_pend,
   input  logic             lo_pend,
   input  logic             strict,
   input  logic [CNT_W-1:0] quota,
   input  logic [CNT_W-1:0] cnt,
   output logic             pick_hi,
   output logic             pick_lo
);
   logic hi_turn;

   assign hi_turn = strict || (cnt < quota);

   always_comb begin
      pick_hi = 1'b0;
      pick_lo = 1'b0;
      if (hi_pend && lo_pend) begin
         pick_hi = hi_turn;
         pick_lo = !hi_turn;
      end else begin
         pick_hi = hi_pend;
         pick_lo = lo_pend;
      end
   end
endmodule

// File: rtl/hl_weighted_arb.sv
module hl_weighted_arb #(
   parameter int unsigned WEIGHT_W = 3,
   parameter int unsigned CNT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hi_pend,
   input  logic                lo_pend,
   input  logic [WEIGHT_W-1:0] weight_code,
   input  logic                pkt_done,
   output logic [1:0]          grant,
   output logic                grant_valid
);
   import hl_arb_pkg::*;

   localparam int unsigned NUM_CODES = 2 ** WEIGHT_W;
   localparam int unsigned MAX_QUOTA = quota_of(NUM_CODES - 2);

   if (WEIGHT_W < 1) begin : g_bad_weight
      $error("hl_weighted_arb: WEIGHT_W must be at least 1");
   end
   if (MAX_QUOTA > (2 ** CNT_W) - 2) begin : g_bad_cnt
      $error("hl_weighted_arb: CNT_W too narrow for largest quota");
   end

   logic [1:0]       grant_q;
   logic             valid_q;
   logic             arb_pt;
   logic             done_hi;
   logic             done_lo;
   logic [CNT_W-1:0] quota;
   logic             strict;
   logic [CNT_W-1:0] cnt_next;
   logic             pick_hi;
   logic             pick_lo;

   assign arb_pt  = !valid_q || pkt_done;
   assign done_hi = valid_q && pkt_done && grant_q[GNT_HI];
   assign done_lo = valid_q && pkt_done && grant_q[GNT_LO];

   hl_quota_dec #(.WEIGHT_W(WEIGHT_W), .CNT_W(CNT_W)) u_dec (
      .code   (weight_code),
      .quota  (quota),
      .strict (strict)
   );

   hl_ratio_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .arb_pt   (arb_pt),
      .done_hi  (done_hi),
      .done_lo  (done_lo),
      .hi_pend  (hi_pend),
      .cnt_next (cnt_next)
   );

   hl_grant_pick #(.CNT_W(CNT_W)) u_pick (
      .hi_pend (hi_pend),
      .lo_pend (lo_pend),
      .strict  (strict),
      .quota   (quota),
      .cnt     (cnt_next),
      .pick_hi (pick_hi),
      .pick_lo (pick_lo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
         valid_q <= 1'b0;
      end else if (arb_pt) begin
         grant_q[GNT_HI] <= pick_hi;
         grant_q[GNT_LO] <= pick_lo;
         valid_q         <= pick_hi || pick_lo;
      end
   end

   assign grant       = grant_q;
   assign grant_valid = valid_q;
endmodule

// File: rtl/hl_arb_chk.sv
module hl_arb_chk #(
   parameter int unsigned WEIGHT_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                hi_pend,
   input logic                lo_pend,
   input logic [WEIGHT_W-1:0] weight_code,
   input logic                pkt_done,
   input logic [1:0]          grant,
   input logic                grant_valid
);
   logic bnd;
   assign bnd = !grant_valid || pkt_done;

   // R4
   hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !pkt_done) |=> (grant_valid && $stable(grant)));

   // R7
   grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid ? ($countones(grant) == 1) : (grant == 2'b00));

   // R7
   both_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && !hi_pend && !lo_pend) |=> !grant_valid);

   // R5
   only_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && hi_pend && !lo_pend) |=> (grant == 2'b01));

   // R5
   only_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && !hi_pend && lo_pend) |=> (grant == 2'b10));

   // R2
   strict_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && hi_pend && (&weight_code)) |=> (grant == 2'b01));
endmodule

bind hl_weighted_arb hl_arb_chk #(.WEIGHT_W(WEIGHT_W)) u_arb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hi_pend     (hi_pend),
   .lo_pend     (lo_pend),
   .weight_code (weight_code),
   .pkt_done    (pkt_done),
   .grant       (grant),
   .grant_valid (grant_valid)
);

// File: tb/test_hl_weighted_arb.sv
module test_hl_weighted_arb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hi_pend = 1'b0;
   logic       lo_pend = 1'b0;
   logic [2:0] weight_code = 3'd0;
   logic       pkt_done = 1'b0;
   logic [1:0] grant;
   logic       grant_valid;

   int n_chk = 0;
   int n_fail = 0;

   // bench-side expectation
   logic [1:0] m_g = 2'b00;
   logic       m_v = 1'b0;
   int         m_cnt = 0;

   always #10 clk = ~clk;

   hl_weighted_arb i_hl_weighted_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .hi_pend     (hi_pend),
      .lo_pend     (lo_pend),
      .weight_code (weight_code),
      .pkt_done    (pkt_done),
      .grant       (grant),
      .grant_valid (grant_valid)
   );

   function automatic int quota(input int c);
      return (c == 0) ? 1 : 2 * c;
   endfunction

   task automatic check(input string req, input logic [1:0] g, input logic v);
      n_chk++;
      if (grant !== g || grant_valid !== v) begin
         n_fail++;
         $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                  req, grant, grant_valid, g, v);
      end
   endtask

   // expected decision at a boundary, from the requirements
   task automatic predict(input bit done);
      if (m_v && done) m_cnt = (m_g == 2'b01) ? ((m_cnt == 15) ? 15 : m_cnt + 1) : 0;
      if (!hi_pend) m_cnt = 0;
      if (hi_pend && lo_pend) begin
         m_g = (weight_code == 3'd7 || m_cnt < quota(int'(weight_code))) ? 2'b01 : 2'b10;
      end else begin
         m_g = {lo_pend, hi_pend};
      end
      m_v = hi_pend || lo_pend;
   endtask

   // at a negedge: set flags, end the packet if one is granted
   task automatic boundary(input logic hi, input logic lo, input string req);
      check({req, " pre-edge hold"}, m_g, m_v);
      hi_pend  = hi;
      lo_pend  = lo;
      pkt_done = m_v;
      predict(1'b1);
      @(negedge clk);
      pkt_done = 1'b0;
      check(req, m_g, m_v);
   endtask

   task automatic hold(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(req, m_g, m_v);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int hi_run;
      repeat (3) @(negedge clk);
      check("R7 reset", 2'b00, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 idle after reset", 2'b00, 1'b0);

      // R7: pkt_done while idle has no effect
      pkt_done = 1'b1;
      @(negedge clk);
      pkt_done = 1'b0;
      check("R7 idle done ignored", 2'b00, 1'b0);

      // R5: only low pending
      boundary(1'b0, 1'b1, "R5 low only");
      hold(2, "R4 low held");
      boundary(1'b0, 1'b0, "R7 both empty");

      // R1/R6 sweep over every ratio code
      for (int c = 0; c < 7; c++) begin
         weight_code = 3'(c);
         boundary(1'b1, 1'b1, "R1 start");
         for (int k = 0; k < 3 * (quota(c) + 1); k++) begin
            boundary(1'b1, 1'b1, "R1 R6 ratio");
         end
         boundary(1'b0, 1'b0, "R7 drain");
      end

      // direct arithmetic run-length check for code 5 (quota 10)
      weight_code = 3'd5;
      boundary(1'b1, 1'b1, "R1 run start");
      hi_run = 0;
      while (m_g == 2'b01) begin
         hi_run++;
         boundary(1'b1, 1'b1, "R1 run");
      end
      n_chk++;
      if (hi_run != 10) begin
         n_fail++;
         $display("FAIL R1: high run=%0d expected=%0d", hi_run, 10);
      end
      boundary(1'b0, 1'b0, "R7 drain");

      // R2: strict priority
      weight_code = 3'd7;
      boundary(1'b1, 1'b1, "R2 start");
      for (int k = 0; k < 20; k++) boundary(1'b1, 1'b1, "R2 strict high");
      boundary(1'b0, 1'b1, "R2 low when high empty");
      boundary(1'b1, 1'b1, "R2 back to high");
      boundary(1'b0, 1'b0, "R7 drain");

      // R3: high runs dry mid-quota, then a full quota follows
      weight_code = 3'd2;
      boundary(1'b1, 1'b1, "R3 first");
      boundary(1'b1, 1'b1, "R3 second");
      boundary(1'b0, 1'b0, "R3 dry");
      boundary(1'b1, 1'b1, "R3 restart");
      hi_run = 0;
      while (m_g == 2'b01) begin
         hi_run++;
         boundary(1'b1, 1'b1, "R3 run");
      end
      n_chk++;
      if (hi_run != 4) begin
         n_fail++;
         $display("FAIL R3: high run after restart=%0d expected=%0d", hi_run, 4);
      end
      check("R3 low after full quota", 2'b10, 1'b1);
      boundary(1'b0, 1'b0, "R7 drain");

      // R5: high alone after its quota is exhausted
      weight_code = 3'd0;
      boundary(1'b1, 1'b1, "R5 setup");
      boundary(1'b1, 1'b0, "R5 high only");
      boundary(1'b1, 1'b0, "R5 high only again");

      // R4: flags change mid packet, grant holds
      hi_pend = 1'b0;
      lo_pend = 1'b1;
      hold(3, "R4 grant held");
      boundary(1'b0, 1'b0, "R7 drain");

      // R8: weight change mid packet only matters at the boundary
      weight_code = 3'd6;
      boundary(1'b1, 1'b1, "R8 start");
      boundary(1'b1, 1'b1, "R8 high");
      boundary(1'b1, 1'b1, "R8 high");
      weight_code = 3'd0;
      hold(2, "R8 mid-packet change ignored");
      boundary(1'b1, 1'b1, "R8 new code at boundary");
      check("R8 low after change", 2'b10, 1'b1);
      boundary(1'b0, 1'b0, "R7 drain");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule